// File: doc/BRIEF.md
# Handle Hash Table Engine

This block keeps a table of object handles in an internal RAM and maps each handle, together with the channel that owns it, to a 32-bit context word. Each table entry is two 32-bit words: the handle sits in the low word and the context word in the high word. A slot's byte offset is its index times 8. The table has 2^HB entries. HB is a parameter from 8 to 12.

Three request ports share one engine: insert, remove and lookup. Each uses a valid/ready handshake, and all three report through one shared response bus. Insert and lookup derive a starting slot from the handle and the channel. They then step through the table one slot per cycle, wrapping at the end. Insert stops at the first free slot. Lookup stops at a matching slot. The offset returned by an insert is what a later remove uses to clear that entry directly. At most one RAM access happens per cycle, and only one request is in flight at a time.

Top module: `hht_engine`

## Requirements
- R1: After reset, rsp_valid is low, and all three ready outputs stay low for 2^HB cycles while every entry is written to zero. After that the table is empty, so a lookup examines exactly one slot and reports a miss.
- R2: A ready output is high only while the engine is idle, and at most one is high at a time. The order of priority is remove, then insert, then lookup. No ready is high while an insert or a lookup is in progress.
- R3: The home slot is found in two steps. First, the handle's bits are XOR-ed together in consecutive HB-bit chunks, starting from bit 0; a short last chunk is padded with zeros. Second, the channel shifted left by HB-4 is XOR-ed in, and any bit at position HB or above is dropped. The first slot probed is at byte offset home slot × 8.
- R4: An entry is free only when both of its words are zero. An insert writes into the first free slot it finds, starting from the home slot and advancing 8 bytes per step. After the last entry it continues at offset 0.
- R5: If an insert examines all 2^HB entries without finding a free one, it responds with status FULL (code 1), offset 0 and context 0, and the table is left unchanged.
- R6: The context word that an insert stores is built as follows:
  - bit 31 is set to 1;
  - bits 28:24 hold the channel;
  - bits 17:16 hold the engine field;
  - bits 15:0 hold the instance address shifted right by 4;
  - all other bits are zero.
- R7: A successful insert responds with op 0 (insert), status OK (code 0), the byte offset of the slot it wrote, and the context word it stored.
- R8: A remove writes zero to both words of the slot given by rem_ofs; bits 2:0 of rem_ofs are ignored. It responds with op 1, status OK, the aligned offset and context 0.
- R9: A lookup (op 2) probes like an insert. It hits on the first entry whose handle word equals the request and whose bits 28:24 equal the requested channel, and it returns status OK, that slot's offset and its context word. It stops with status MISS (code 2), offset 0 and context 0 when it reaches a free entry.
- R10: A lookup that examines all 2^HB entries without a hit or a free entry responds MISS.
- R11: Response timing depends on the request. An insert or lookup that examines k slots raises rsp_valid at the k-th rising edge after the edge that accepts it. A remove raises rsp_valid at the accepting edge itself. Either way, rsp_valid then stays high for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request valid |
| ins_ready | output | 1 | Insert request accepted this cycle |
| ins_handle | input | 32 | Handle to insert |
| ins_chan | input | CW | Owning channel of the new entry |
| ins_engine | input | EW | Engine field for the context word |
| ins_inst | input | IW | Instance address (stored shifted right by 4) |
| rem_valid | input | 1 | Remove request valid |
| rem_ready | output | 1 | Remove request accepted this cycle |
| rem_ofs | input | HB+3 | Byte offset of the entry to clear |
| lkp_valid | input | 1 | Lookup request valid |
| lkp_ready | output | 1 | Lookup request accepted this cycle |
| lkp_handle | input | 32 | Handle to search for |
| lkp_chan | input | CW | Channel to search for |
| rsp_valid | output | 1 | Response strobe |
| rsp_op | output | 2 | Request kind: 0 insert, 1 remove, 2 lookup |
| rsp_status | output | 2 | 0 OK, 1 FULL, 2 MISS |
| rsp_ofs | output | HB+3 | Byte offset of the affected slot |
| rsp_ctx | output | 32 | Context word stored or found |

## Verification
The checker assumes that requesters hold their fields steady while valid is high. It also assumes that remove offsets name slots returned earlier, so clearing them never splits a probe chain that the bench does not model. The bench drives every request at the falling edge and then holds it until the ready it waits for. It passes remove only offsets that it recorded from earlier insert responses. A reference model in the bench probes the same slots, so broken chains after a remove are predicted rather than avoided. The priority checks raise several valids at once, then drop them again before the next rising edge.

// File: rtl/hht_pkg.sv
package hht_pkg;

   typedef enum logic [1:0] {
      OP_INS = 2'd0,
      OP_REM = 2'd1,
      OP_LKP = 2'd2
   } hht_op_t;

   typedef enum logic [1:0] {
      STS_OK   = 2'd0,
      STS_FULL = 2'd1,
      STS_MISS = 2'd2
   } hht_sts_t;

   typedef enum logic [1:0] {
      ST_INIT  = 2'd0,
      ST_IDLE  = 2'd1,
      ST_PROBE = 2'd2
   } hht_state_t;

   // context word field positions
   localparam int CTX_VALID_BIT = 31;
   localparam int CTX_CHAN_LSB  = 24;
   localparam int CTX_CHAN_W    = 5;
   localparam int CTX_ENG_LSB   = 16;
   localparam int CTX_ENG_W     = 2;
   localparam int CTX_INST_W    = 16;

   function automatic logic [31:0] make_ctx(input logic [CTX_CHAN_W-1:0] ch,
                                            input logic [CTX_ENG_W-1:0]  eng,
                                            input logic [CTX_INST_W-1:0] ia);
      logic [31:0] w;
      w = '0;
      w[CTX_VALID_BIT] = 1'b1;
      w[CTX_CHAN_LSB +: CTX_CHAN_W] = ch;
      w[CTX_ENG_LSB  +: CTX_ENG_W]  = eng;
      w[0 +: CTX_INST_W] = ia;
      return w;
   endfunction

endpackage

// File: rtl/hht_hash.sv
module hht_hash #(
   parameter int HB = 8,
   parameter int CW = 5
) (
   input  logic [31:0]   key,
   input  logic [CW-1:0] chan,
   output logic [HB-1:0] slot
);
   localparam int NCH  = (32 + HB - 1) / HB;
   localparam int PADW = NCH * HB;

   logic [PADW-1:0] pad;
   logic [HB-1:0]   fold [NCH+1];
   logic [HB-1:0]   chx;

   assign pad     = PADW'(key);
   assign fold[0] = '0;

   for (genvar i = 0; i < NCH; i++) begin : g_fold
      assign fold[i+1] = fold[i] ^ pad[i*HB +: HB];
   end

   assign chx  = HB'(chan) << (HB - 4);
   assign slot = fold[NCH] ^ chx;

endmodule

// File: rtl/hht_arb.sv
module hht_arb #(
   parameter int N = 3
) (
   input  logic         idle,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   // index 0 has the highest priority
   always_comb begin
      logic taken;
      taken = !idle;
      for (int i = 0; i < N; i++) begin
         gnt[i] = req[i] & !taken;
         taken  = taken | req[i];
      end
   end

endmodule

// File: rtl/hht_ram.sv
module hht_ram #(
   parameter int AW = 8,
   parameter int DW = 64
) (
   input  logic          clk,
   input  logic          en,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (en) begin
         if (we) mem[addr] <= wdata;
         else    rdata     <= mem[addr];
      end
   end

endmodule

// File: rtl/hht_engine.sv
module hht_engine
   import hht_pkg::*;
#(
   parameter int HB = 8,
   parameter int CW = 5,
   parameter int EW = 2,
   parameter int IW = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ins_valid,
   output logic          ins_ready,
   input  logic [31:0]   ins_handle,
   input  logic [CW-1:0] ins_chan,
   input  logic [EW-1:0] ins_engine,
   input  logic [IW-1:0] ins_inst,
   input  logic          rem_valid,
   output logic          rem_ready,
   input  logic [HB+2:0] rem_ofs,
   input  logic          lkp_valid,
   output logic          lkp_ready,
   input  logic [31:0]   lkp_handle,
   input  logic [CW-1:0] lkp_chan,
   output logic          rsp_valid,
   output logic [1:0]    rsp_op,
   output logic [1:0]    rsp_status,
   output logic [HB+2:0] rsp_ofs,
   output logic [31:0]   rsp_ctx
);
   localparam int DEPTH = 1 << HB;
   localparam int OFW   = HB + 3;
   localparam int DW    = 64;
   localparam int NPORT = 3;

   if (HB < 8 || HB > 12) begin : g_bad_hb
      $error("hht_engine: HB must lie in 8..12");
   end
   if (CW != CTX_CHAN_W) begin : g_bad_cw
      $error("hht_engine: CW must match the channel field width");
   end
   if (EW != CTX_ENG_W) begin : g_bad_ew
      $error("hht_engine: EW must match the engine field width");
   end
   if (IW < 5 || IW > CTX_INST_W + 4) begin : g_bad_iw
      $error("hht_engine: IW out of range");
   end

   hht_state_t       state_q;
   hht_op_t          op_q;
   logic [HB-1:0]    idx_q, start_q, nxt_idx;
   logic [31:0]      key_q, ctx_q;
   logic [CW-1:0]    chan_q;

   logic [NPORT-1:0] req, gnt;
   logic             g_rem, g_ins, g_lkp;
   logic [31:0]      h_key;
   logic [CW-1:0]    h_chan;
   logic [HB-1:0]    h_slot, rem_slot;
   logic [OFW-1:0]   rem_aligned;

   logic             ram_en, ram_we;
   logic [HB-1:0]    ram_addr;
   logic [DW-1:0]    ram_wdata, ram_rdata;

   logic             ent_free, ent_hit, wrap_end;
   logic [31:0]      new_ctx;

   // request selection
   assign req   = {lkp_valid, ins_valid, rem_valid};
   hht_arb #(.N(NPORT)) u_arb (
      .idle (state_q == ST_IDLE),
      .req  (req),
      .gnt  (gnt)
   );
   assign g_rem     = gnt[0];
   assign g_ins     = gnt[1];
   assign g_lkp     = gnt[2];
   assign rem_ready = g_rem;
   assign ins_ready = g_ins;
   assign lkp_ready = g_lkp;

   // home slot for the request being accepted
   assign h_key  = g_ins ? ins_handle : lkp_handle;
   assign h_chan = g_ins ? ins_chan   : lkp_chan;
   hht_hash #(.HB(HB), .CW(CW)) u_hash (
      .key  (h_key),
      .chan (h_chan),
      .slot (h_slot)
   );

   assign rem_aligned = rem_ofs & ~OFW'(7);
   assign rem_slot    = HB'(rem_ofs >> 3);
   assign new_ctx     = make_ctx(CTX_CHAN_W'(ins_chan), CTX_ENG_W'(ins_engine),
                                 CTX_INST_W'(ins_inst >> 4));

   // probe evaluation
   assign nxt_idx  = idx_q + 1'b1;
   assign wrap_end = (nxt_idx == start_q);
   assign ent_free = (ram_rdata == '0);
   assign ent_hit  = !ent_free && (ram_rdata[31:0] == key_q) &&
                     (ram_rdata[32+CTX_CHAN_LSB +: CTX_CHAN_W] == CTX_CHAN_W'(chan_q));

   hht_ram #(.AW(HB), .DW(DW)) u_ram (
      .clk   (clk),
      .en    (ram_en),
      .we    (ram_we),
      .addr  (ram_addr),
      .wdata (ram_wdata),
      .rdata (ram_rdata)
   );

   // single RAM port steering
   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = idx_q;
      ram_wdata = '0;
      unique case (state_q)
         ST_INIT: begin
            ram_en = 1'b1;
            ram_we = 1'b1;
         end
         ST_IDLE: begin
            if (g_rem) begin
               ram_en   = 1'b1;
               ram_we   = 1'b1;
               ram_addr = rem_slot;
            end else if (g_ins || g_lkp) begin
               ram_en   = 1'b1;
               ram_addr = h_slot;
            end
         end
         ST_PROBE: begin
            if (op_q == OP_INS && ent_free) begin
               ram_en    = 1'b1;
               ram_we    = 1'b1;
               ram_wdata = {ctx_q, key_q};
            end else if (!ent_free && !(op_q == OP_LKP && ent_hit) && !wrap_end) begin
               ram_en   = 1'b1;
               ram_addr = nxt_idx;
            end
         end
         default: ;
      endcase
   end

   // control and response registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_INIT;
         op_q       <= OP_INS;
         idx_q      <= '0;
         start_q    <= '0;
         key_q      <= '0;
         ctx_q      <= '0;
         chan_q     <= '0;
         rsp_valid  <= 1'b0;
         rsp_op     <= '0;
         rsp_status <= '0;
         rsp_ofs    <= '0;
         rsp_ctx    <= '0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            ST_INIT: begin
               idx_q <= nxt_idx;
               if (idx_q == HB'(DEPTH - 1)) state_q <= ST_IDLE;
            end
            ST_IDLE: begin
               if (g_rem) begin
                  rsp_valid  <= 1'b1;
                  rsp_op     <= OP_REM;
                  rsp_status <= STS_OK;
                  rsp_ofs    <= rem_aligned;
                  rsp_ctx    <= '0;
               end else if (g_ins || g_lkp) begin
                  state_q <= ST_PROBE;
                  op_q    <= g_ins ? OP_INS : OP_LKP;
                  idx_q   <= h_slot;
                  start_q <= h_slot;
                  key_q   <= h_key;
                  chan_q  <= h_chan;
                  ctx_q   <= g_ins ? new_ctx : '0;
               end
            end
            ST_PROBE: begin
               if (op_q == OP_INS && ent_free) begin
                  state_q    <= ST_IDLE;
                  rsp_valid  <= 1'b1;
                  rsp_op     <= OP_INS;
                  rsp_status <= STS_OK;
                  rsp_ofs    <= {idx_q, 3'b000};
                  rsp_ctx    <= ctx_q;
               end else if (op_q == OP_LKP && (ent_free || ent_hit)) begin
                  state_q    <= ST_IDLE;
                  rsp_valid  <= 1'b1;
                  rsp_op     <= OP_LKP;
                  rsp_status <= ent_hit ? STS_OK : STS_MISS;
                  rsp_ofs    <= ent_hit ? {idx_q, 3'b000} : '0;
                  rsp_ctx    <= ent_hit ? ram_rdata[63:32] : '0;
               end else if (wrap_end) begin
                  state_q    <= ST_IDLE;
                  rsp_valid  <= 1'b1;
                  rsp_op     <= op_q;
                  rsp_status <= (op_q == OP_INS) ? STS_FULL : STS_MISS;
                  rsp_ofs    <= '0;
                  rsp_ctx    <= '0;
               end else begin
                  idx_q <= nxt_idx;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/hht_engine_chk.sv
module hht_engine_chk #(
   parameter int HB = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ins_valid,
   input logic          ins_ready,
   input logic          rem_valid,
   input logic          rem_ready,
   input logic          lkp_valid,
   input logic          lkp_ready,
   input logic          rsp_valid,
   input logic [1:0]    rsp_op,
   input logic [1:0]    rsp_status,
   input logic [HB+2:0] rsp_ofs,
   input logic [31:0]   rsp_ctx
);
   localparam int DEPTH = 1 << HB;

   logic [HB:0] cyc_q;
   logic        any_rdy;

   assign any_rdy = ins_ready | rem_ready | lkp_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cyc_q <= '0;
      else if (cyc_q < (HB+1)'(DEPTH)) cyc_q <= cyc_q + 1'b1;
   end

   // R1
   init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_q < (HB+1)'(DEPTH)) |-> !any_rdy);

   // R2
   ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ins_ready, rem_ready, lkp_ready}));

   // R2
   rem_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_valid && any_rdy) |-> rem_ready);

   // R2
   ins_over_lkp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_valid && !rem_valid && any_rdy) |-> ins_ready);

   // R2
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ins_valid && ins_ready) || (lkp_valid && lkp_ready)) |=> !any_rdy);

   // R11
   rem_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_valid && rem_ready) |=> (rsp_valid && rsp_op == 2'd1 && rsp_status == 2'd0));

   // R5
   full_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'd1) |-> (rsp_op == 2'd0 && rsp_ctx == 32'd0));

   // R9
   miss_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status == 2'd2) |-> (rsp_op == 2'd2 && rsp_ofs == '0));

   // R6
   ctx_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_op == 2'd0 && rsp_status == 2'd0) |-> rsp_ctx[31]);

   // R7
   ofs_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_ofs[2:0] == 3'b000));

endmodule

bind hht_engine hht_engine_chk #(.HB(HB)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ins_valid  (ins_valid),
   .ins_ready  (ins_ready),
   .rem_valid  (rem_valid),
   .rem_ready  (rem_ready),
   .lkp_valid  (lkp_valid),
   .lkp_ready  (lkp_ready),
   .rsp_valid  (rsp_valid),
   .rsp_op     (rsp_op),
   .rsp_status (rsp_status),
   .rsp_ofs    (rsp_ofs),
   .rsp_ctx    (rsp_ctx)
);

// File: tb/sim_hht_engine.sv
`timescale 1ns/1ps
module sim_hht_engine;
   localparam int HB    = 8;
   localparam int DEPTH = 1 << HB;
   localparam int OFW   = HB + 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           ins_valid = 1'b0, rem_valid = 1'b0, lkp_valid = 1'b0;
   logic           ins_ready, rem_ready, lkp_ready;
   logic [31:0]    ins_handle = '0, lkp_handle = '0;
   logic [4:0]     ins_chan = '0, lkp_chan = '0;
   logic [1:0]     ins_engine = '0;
   logic [19:0]    ins_inst = '0;
   logic [OFW-1:0] rem_ofs = '0;
   logic           rsp_valid;
   logic [1:0]     rsp_op, rsp_status;
   logic [OFW-1:0] rsp_ofs;
   logic [31:0]    rsp_ctx;

   always #5 clk = ~clk;

   hht_engine #(.HB(HB)) u0 (
      .clk(clk), .rst_n(rst_n),
      .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_handle(ins_handle),
      .ins_chan(ins_chan), .ins_engine(ins_engine), .ins_inst(ins_inst),
      .rem_valid(rem_valid), .rem_ready(rem_ready), .rem_ofs(rem_ofs),
      .lkp_valid(lkp_valid), .lkp_ready(lkp_ready), .lkp_handle(lkp_handle),
      .lkp_chan(lkp_chan),
      .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_status(rsp_status),
      .rsp_ofs(rsp_ofs), .rsp_ctx(rsp_ctx)
   );

   int n_chk = 0, n_bad = 0;
   logic [31:0] mh [DEPTH];
   logic [31:0] mc [DEPTH];

   // remembered live entries for random removes and lookups
   logic [31:0]    live_h [512];
   logic [4:0]     live_c [512];
   logic [OFW-1:0] live_o [512];
   int n_live = 0;

   task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   function automatic logic [HB-1:0] f_home(input logic [31:0] h, input logic [4:0] ch);
      logic [HB-1:0] acc;
      logic [31:0] chs;
      acc = '0;
      for (int i = 0; i < 32; i += HB) acc ^= HB'(h >> i);
      chs = 32'(ch) << (HB - 4);
      return acc ^ chs[HB-1:0];
   endfunction

   function automatic logic [31:0] f_ctx(input logic [4:0] ch, input logic [1:0] e, input logic [19:0] ia);
      return 32'h8000_0000 | (32'(ch) << 24) | (32'(e) << 16) | 32'(ia[19:4]);
   endfunction

   function automatic logic [55:0] pk(input int op, input int st, input logic [OFW-1:0] o, input logic [31:0] c);
      return {4'(op), 4'(st), 16'(o), c};
   endfunction

   task automatic issue(input int op, input logic [31:0] h, input logic [4:0] ch,
                        input logic [1:0] e, input logic [19:0] ia, input logic [OFW-1:0] o,
                        output logic [55:0] got, output int lat);
      logic rdy;
      @(negedge clk);
      case (op)
         0: begin ins_valid = 1; ins_handle = h; ins_chan = ch; ins_engine = e; ins_inst = ia; end
         1: begin rem_valid = 1; rem_ofs = o; end
         default: begin lkp_valid = 1; lkp_handle = h; lkp_chan = ch; end
      endcase
      #1;
      rdy = (op == 0) ? ins_ready : (op == 1) ? rem_ready : lkp_ready;
      while (!rdy) begin
         @(negedge clk); #1;
         rdy = (op == 0) ? ins_ready : (op == 1) ? rem_ready : lkp_ready;
      end
      @(posedge clk); #1;
      ins_valid = 0; rem_valid = 0; lkp_valid = 0;
      lat = 0;
      do begin @(negedge clk); lat++; end while (!rsp_valid && lat < 5000);
      got = {4'(rsp_op), 4'(rsp_status), 16'(rsp_ofs), rsp_ctx};
   endtask

   task automatic do_insert(input string r, input logic [31:0] h, input logic [4:0] ch,
                            input logic [1:0] e, input logic [19:0] ia,
                            output int st, output logic [OFW-1:0] o);
      logic [HB-1:0] s, base;
      logic [55:0] got;
      int probes, lat;
      logic [31:0] c;
      base = f_home(h, ch);
      st = 1; o = '0; c = '0; probes = DEPTH;
      for (int k = 0; k < DEPTH; k++) begin
         s = base + HB'(k);
         if (mh[s] == 0 && mc[s] == 0) begin
            st = 0; o = {s, 3'b000}; c = f_ctx(ch, e, ia); probes = k + 1;
            mh[s] = h; mc[s] = c;
            break;
         end
      end
      issue(0, h, ch, e, ia, '0, got, lat);
      chk({r, " insert response"}, 64'(got), 64'(pk(0, st, o, c)));
      chk({r, " R11 insert latency"}, 64'(lat), 64'(probes + 1));
   endtask

   task automatic do_lookup(input string r, input logic [31:0] h, input logic [4:0] ch);
      logic [HB-1:0] s, base;
      logic [55:0] got;
      int probes, lat, st;
      logic [OFW-1:0] o;
      logic [31:0] c;
      base = f_home(h, ch);
      st = 2; o = '0; c = '0; probes = DEPTH;
      for (int k = 0; k < DEPTH; k++) begin
         s = base + HB'(k);
         if (mh[s] == 0 && mc[s] == 0) begin probes = k + 1; break; end
         if (mh[s] == h && mc[s][28:24] == ch) begin
            st = 0; o = {s, 3'b000}; c = mc[s]; probes = k + 1; break;
         end
      end
      issue(2, h, ch, 0, 0, '0, got, lat);
      chk({r, " lookup response"}, 64'(got), 64'(pk(2, st, o, c)));
      chk({r, " R11 lookup latency"}, 64'(lat), 64'(probes + 1));
   endtask

   task automatic do_remove(input string r, input logic [OFW-1:0] o);
      logic [55:0] got;
      int lat;
      logic [HB-1:0] s;
      s = HB'(o >> 3);
      mh[s] = 0; mc[s] = 0;
      issue(1, 0, 0, 0, 0, o, got, lat);
      chk({r, " remove response"}, 64'(got), 64'(pk(1, 0, {s, 3'b000}, 0)));
      chk({r, " R11 remove latency"}, 64'(lat), 64'd1);
   endtask

   initial begin
      #(10 * 190000);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int st, pick;
      logic [OFW-1:0] o, o_a, o_b, o_c, o_w;
      logic [31:0] h;
      logic [4:0] ch;
      logic [2:0] rd;
      void'($urandom(32'd20240611));
      for (int i = 0; i < DEPTH; i++) begin mh[i] = 0; mc[i] = 0; end

      // R1: reset and clearing sweep
      ins_valid = 1;
      repeat (4) @(negedge clk);
      chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
      chk("R1 ready in reset", 64'(ins_ready), 64'd0);
      rst_n = 1;
      repeat (100) @(negedge clk);
      chk("R1 ready during clear", 64'({ins_ready, rem_ready, lkp_ready}), 64'd0);
      ins_valid = 0;
      repeat (DEPTH) @(negedge clk);
      do_lookup("R1 empty table", 32'hdead_beef, 5'd7);

      // R3 R6 R7: plain insert and hit
      do_insert("R3 R6 R7 first", 32'h1234_5678, 5'd3, 2'd1, 20'hABCDE, st, o);
      do_lookup("R9 hit", 32'h1234_5678, 5'd3);
      do_lookup("R9 channel mismatch", 32'h1234_5678, 5'd4);

      // R4: collisions on home slot 1
      do_insert("R4 chain a", 32'h0000_0001, 5'd0, 2'd2, 20'h00010, st, o_a);
      do_insert("R4 chain b", 32'h0000_0100, 5'd0, 2'd3, 20'h00020, st, o_b);
      do_insert("R4 chain c", 32'h0001_0000, 5'd0, 2'd0, 20'h00030, st, o_c);
      do_lookup("R9 chain end hit", 32'h0001_0000, 5'd0);
      do_lookup("R9 chain miss", 32'h0100_0000, 5'd0);
      do_lookup("R3 channel hash", 32'h0000_0001, 5'd1);

      // R4: wrap from the last slot to offset 0
      do_insert("R4 last slot", 32'h0000_00FF, 5'd0, 2'd1, 20'hFFFF0, st, o);
      do_insert("R4 wrap", 32'h0000_FF00, 5'd0, 2'd1, 20'h12340, st, o_w);
      chk("R4 wrap offset", 64'(o_w), 64'd0);

      // R2: priority among simultaneous requests
      @(negedge clk);
      rem_valid = 1; ins_valid = 1; lkp_valid = 1; #1;
      chk("R2 remove first", 64'({rem_ready, ins_ready, lkp_ready}), 64'b100);
      rem_valid = 0; #1;
      chk("R2 insert over lookup", 64'({rem_ready, ins_ready, lkp_ready}), 64'b010);
      ins_valid = 0; #1;
      chk("R2 lookup alone", 64'({rem_ready, ins_ready, lkp_ready}), 64'b001);
      lkp_valid = 0;

      // R8: remove with unaligned offset, broken chain, reuse
      do_remove("R8 unaligned", o_b | OFW'(5));
      do_lookup("R8 cleared slot stops probe", 32'h0001_0000, 5'd0);
      do_lookup("R8 earlier entry kept", 32'h0000_0001, 5'd0);
      do_insert("R8 slot reuse", 32'h0000_0200, 5'd0, 2'd0, 20'h00040, st, o);
      chk("R8 reuse offset", 64'(o), 64'(o_b));

      // constrained random mix
      for (int n = 0; n < 300; n++) begin
         rd = 3'($urandom % 8);
         if (rd < 4 || n_live == 0) begin
            h  = ($urandom % 2) ? $urandom : (32'($urandom % 4) << 16) | 32'($urandom % 4);
            ch = 5'($urandom);
            do_insert("R4 R7 random", h, ch, 2'($urandom), 20'($urandom), st, o);
            if (st == 0 && n_live < 512) begin
               live_h[n_live] = h; live_c[n_live] = ch; live_o[n_live] = o; n_live++;
            end
         end else if (rd < 6) begin
            pick = int'($urandom % n_live);
            if ($urandom % 3 == 0) do_lookup("R9 random miss", $urandom, 5'($urandom));
            else                   do_lookup("R9 random known", live_h[pick], live_c[pick]);
         end else begin
            pick = int'($urandom % n_live);
            do_remove("R8 random", live_o[pick]);
            n_live--;
            live_h[pick] = live_h[n_live]; live_c[pick] = live_c[n_live]; live_o[pick] = live_o[n_live];
         end
      end

      // R5 R10: fill the table
      for (int k = 0; k <= DEPTH; k++) begin
         do_insert("R5 fill", 32'h8000_0000 + 32'(k * 7), 5'(k), 2'd1, 20'(k << 4), st, o);
         if (st == 1) break;
      end
      do_insert("R5 full again", 32'h7777_0000, 5'd2, 2'd3, 20'h55550, st, o);
      chk("R5 full status", 64'(st), 64'd1);
      do_lookup("R10 full wrap miss", 32'h7777_0000, 5'd2);
      do_remove("R8 free one", o_a);
      do_insert("R5 after free", 32'h7777_0000, 5'd2, 2'd3, 20'h55550, st, o);
      chk("R5 lands in freed slot", 64'(o), 64'(o_a));

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule